// File: doc/BRIEF.md
# SMBus Register Slave

This block is a target-side SMBus controller for a chip's register space. It oversamples the open-drain SCL and SDA lines with the system clock. It recognises start and stop conditions and answers to one 7-bit device address. Three transactions are served. A send-byte transaction loads an internal register pointer. A write-byte transaction loads the pointer and then writes one data byte to that register. A receive-byte transaction returns the register the pointer selects.

The pointer is kept between transactions and is never changed by a read, so a host can poll one register with repeated receive-byte transactions. Accesses reach the surrounding register file through a plain port: address, write data, a one-cycle write strobe, a one-cycle read strobe and read data.

One byte-wide configuration register lives inside the block at a fixed pointer value. One of its bits turns off a bus-inactivity watchdog. When the watchdog is on and a transaction sees no line activity for a programmable time, the slave lets go of SDA and drops the transaction.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, SDA is not driven, both strobes are low, the register address output is 0x00 and the configuration register reads 0x00.
- R2: A write-byte transaction is start, the device address with R/W bit 0, the pointer byte, the data byte, then stop. The slave ACKs each of the three bytes. It gives exactly one single-cycle reg_we pulse, with reg_addr equal to the pointer byte and reg_wdata equal to the data byte.
- R3: A send-byte transaction is start, the address with R/W bit 0, one byte, then stop. It sets the pointer, which appears on reg_addr, and produces no write strobe.
- R4: A receive-byte transaction is start, then the address with R/W bit 1. The slave ACKs and drives the selected register MSB first, and the master ends it with NACK and stop. The pointer stays unchanged, so back-to-back reads return the same register.
- R5: If the address byte does not carry the device address, the slave gives no ACK and no strobe. It also ignores every following byte until the next start or stop.
- R6: A repeated start restarts address decoding at any point of a transaction, so a pointer load can be followed at once by a read.
- R7: When the watchdog is enabled and an active transaction sees no SCL or SDA edge for TIMEOUT_MS milliseconds of clk, SDA is released. The slave then waits for a new start and serves it normally.
- R8: The configuration register sits at pointer CFG_ADDR (default 0x40). It is written and read through the normal transactions and never raises reg_we. Setting bit TODIS_BIT (default 6) to 1 disables the watchdog, so SDA stays driven however long the bus stalls.
- R9: The slave only ever pulls SDA low, and it starts pulling only while SCL is low.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop always leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | When 1, SDA is pulled low; when 0, released |
| reg_addr | output | 8 | Current register pointer |
| reg_wdata | output | 8 | Data byte for a register write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe; reg_rdata must hold from the next cycle until the address ACK ends |
| reg_rdata | input | 8 | Register contents returned for a read |

## Verification
The hardest situation to reach is a stalled read in which the slave is holding SDA low at the moment the watchdog runs out. The stimulus points the pointer at a register that holds 0x00 and starts a receive-byte. It clocks out only the first data bit and then parks SCL low, so the slave is driving the second zero bit. The bench checks that SDA is still low part way through the timeout window and released after it. With the disable bit set, the same stall lasts more than twice the window without release, and the remaining bits are then clocked out to finish the byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_READ,
    ST_IGNORE
  } smb_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic line_edge
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] now_v;
  logic [NLINES-1:0] prev_v;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              held;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        held  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        held  <= chain[STAGES-1];
      end
    end
    assign now_v[g]  = chain[STAGES-1];
    assign prev_v[g] = held;
  end

  assign scl_lvl   = now_v[0];
  assign sda_lvl   = now_v[1];
  assign scl_rise  = now_v[0] & ~prev_v[0];
  assign scl_fall  = ~now_v[0] & prev_v[0];
  assign start_det = now_v[0] & prev_v[0] & prev_v[1] & ~now_v[1];
  assign stop_det  = now_v[0] & prev_v[0] & ~prev_v[1] & now_v[1];
  assign line_edge = |(now_v ^ prev_v);

endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int unsigned LIMIT = 1750000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic enable,
  input  logic activity,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active || !enable || activity) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == CW'(LIMIT - 1)) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end

  AST_TO_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) !enable |=> !expire); // R8
  AST_TO_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !active |=> !expire); // R7

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_pkg::*;
#(
  parameter int             DW        = 8,
  parameter logic [DW-2:0]  DEV_ADDR  = 7'h2E,
  parameter logic [DW-1:0]  CFG_ADDR  = 8'h40,
  parameter int             TODIS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          to_expire,
  input  logic [DW-1:0] reg_rdata,
  output logic          sda_oe,
  output logic          busy,
  output logic          to_disable,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  smb_state_t    st;
  logic [DW-1:0] sh;
  logic [BW-1:0] bcnt;
  logic          full;
  logic          rnw;
  logic [DW-1:0] ptr;
  logic [DW-1:0] cfg;
  logic          collecting;
  logic [DW-1:0] rd_src;

  assign collecting = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_DATA);
  assign rd_src     = (ptr == CFG_ADDR) ? cfg : reg_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sh        <= '0;
      bcnt      <= '0;
      full      <= 1'b0;
      rnw       <= 1'b0;
      ptr       <= '0;
      cfg       <= '0;
      sda_oe    <= 1'b0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bcnt   <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det || to_expire) begin
        st     <= ST_IDLE;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (collecting && scl_rise && !full) begin
        sh   <= {sh[DW-2:0], sda_lvl};
        bcnt <= bcnt + 1'b1;
        if (bcnt == LAST_BIT) full <= 1'b1;
      end else if (scl_fall) begin
        case (st)
          ST_ADDR: if (full) begin
            full <= 1'b0;
            if (sh[DW-1:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rnw    <= sh[0];
              st     <= ST_ADDR_ACK;
              if (sh[0] && (ptr != CFG_ADDR)) reg_re <= 1'b1;
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_PTR: if (full) begin
            full   <= 1'b0;
            ptr    <= sh;
            sda_oe <= 1'b1;
            st     <= ST_PTR_ACK;
          end
          ST_DATA: if (full) begin
            full   <= 1'b0;
            sda_oe <= 1'b1;
            st     <= ST_DATA_ACK;
            if (ptr == CFG_ADDR) begin
              cfg <= sh;
            end else begin
              reg_we    <= 1'b1;
              reg_wdata <= sh;
            end
          end
          ST_ADDR_ACK: begin
            bcnt <= '0;
            if (rnw) begin
              sh     <= rd_src;
              sda_oe <= ~rd_src[DW-1];
              st     <= ST_READ;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
          ST_PTR_ACK: begin
            sda_oe <= 1'b0;
            st     <= ST_DATA;
          end
          ST_DATA_ACK: begin
            sda_oe <= 1'b0;
            st     <= ST_IGNORE;
          end
          ST_READ: begin
            if (bcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_IGNORE;
            end else begin
              sda_oe <= ~sh[DW-2];
              sh     <= {sh[DW-2:0], 1'b0};
              bcnt   <= bcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy       = (st != ST_IDLE);
  assign to_disable = cfg[TODIS_BIT];
  assign reg_addr   = ptr;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !$past(scl_lvl)); // R9
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we); // R2
  AST_CFG_NO_STROBE: assert property (@(posedge clk) disable iff (rst) reg_we |-> (reg_addr != CFG_ADDR)); // R8
  AST_TO_RELEASE: assert property (@(posedge clk) disable iff (rst) to_expire |=> !sda_oe); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe); // R10
  AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst) reg_re |=> $stable(reg_addr)); // R4

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h2E,
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 35,
  parameter logic [7:0]  CFG_ADDR    = 8'h40,
  parameter int          TODIS_BIT   = 6,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);

  localparam int          DW        = 8;
  localparam int unsigned TO_CYCLES = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic start_det, stop_det, line_edge;
  logic busy, to_disable, to_expire;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .line_edge (line_edge)
  );

  smb_timeout #(.LIMIT(TO_CYCLES)) u_to (
    .clk      (clk),
    .rst      (rst),
    .active   (busy),
    .enable   (!to_disable),
    .activity (line_edge),
    .expire   (to_expire)
  );

  smb_slave_fsm #(
    .DW        (DW),
    .DEV_ADDR  (DEV_ADDR),
    .CFG_ADDR  (CFG_ADDR),
    .TODIS_BIT (TODIS_BIT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (scl_lvl),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .to_expire  (to_expire),
    .reg_rdata  (reg_rdata),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .to_disable (to_disable),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re)
  );

endmodule

// File: tb/sim_smb_reg_slave.sv
module sim_smb_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 20;
  localparam logic [6:0] DEV = 7'h2E;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_pull = 1'b0;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic       sda_line;

  assign sda_line = ~(sda_pull | sda_oe);

  always #(CLK_PERIOD / 2) clk = ~clk;

  smb_reg_slave #(.DEV_ADDR(DEV), .CLK_FREQ_HZ(100_000), .TIMEOUT_MS(35)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] cfg_shadow;
  int n_chk = 0;
  int n_fail = 0;
  int drive_viol = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t wr_q[$];
  logic [7:0] rd_q[$];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    cfg_shadow = 8'h00;
    reg_rdata  = 8'h00;
  end

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor for register writes (R2, R3, R5, R8)
  logic oe_q = 1'b0;
  logic scl_q = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        if (wr_q.size() == 0) begin
          check(1'b0, "R2", "unexpected reg_we at addr", {24'd0, reg_addr}, 32'hFFFF);
        end else begin
          wr_t e;
          e = wr_q.pop_front();
          check(reg_addr == e.a && reg_wdata == e.d, "R2", "write addr/data",
                {16'd0, reg_addr, reg_wdata}, {16'd0, e.a, e.d});
        end
      end
      if (sda_oe && !oe_q && scl_q) drive_viol++;
    end
    oe_q  <= sda_oe;
    scl_q <= scl;
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_pull = 1'b0; scl = 1'b1; wait_h(H);
    sda_pull = 1'b1; wait_h(H);
    scl = 1'b0; wait_h(H);
  endtask

  task automatic bus_rstart;
    wait_h(2); sda_pull = 1'b0; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_pull = 1'b1; wait_h(H);
    scl = 1'b0; wait_h(H);
  endtask

  task automatic bus_stop;
    wait_h(2); sda_pull = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_pull = 1'b0; wait_h(H);
  endtask

  task automatic send_bit(input bit b);
    wait_h(2); sda_pull = ~b; wait_h(H - 2);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic recv_bit(output bit b);
    wait_h(2); sda_pull = 1'b0; wait_h(H - 2);
    scl = 1'b1; wait_h(H / 2);
    b = sda_line; wait_h(H / 2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d);
    bit k0, k1, k2;
    if (a == 8'h40) cfg_shadow = d;
    else begin
      wr_q.push_back({a, d});
      shadow[a] = d;
    end
    bus_start;
    send_byte({DEV, 1'b0}, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop;
    check(k0 && k1 && k2, "R2", "three ACKs on write byte", {29'd0, k0, k1, k2}, 32'h7);
  endtask

  task automatic ptr_txn(input logic [7:0] a);
    bit k0, k1;
    bus_start;
    send_byte({DEV, 1'b0}, k0);
    send_byte(a, k1);
    bus_stop;
    check(k0 && k1, "R3", "ACKs on send byte", {30'd0, k0, k1}, 32'h3);
    check(reg_addr == a, "R3", "pointer after send byte", {24'd0, reg_addr}, {24'd0, a});
  endtask

  task automatic read_txn(input string rq, input logic [7:0] exp);
    bit k;
    logic [7:0] d, e;
    rd_q.push_back(exp);
    bus_start;
    send_byte({DEV, 1'b1}, k);
    recv_byte(d, 1'b1);
    bus_stop;
    e = rd_q.pop_front();
    check(k, rq, "read address ACK", {31'd0, k}, 32'h1);
    check(d == e, rq, "read data", {24'd0, d}, {24'd0, e});
  endtask

  initial begin
    bit k, b0;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    wait_h(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'd0, sda_oe}, 32'h0);
    check(!reg_we && !reg_re, "R1", "strobes after reset", {30'd0, reg_we, reg_re}, 32'h0);
    check(reg_addr == 8'h00, "R1", "reg_addr after reset", {24'd0, reg_addr}, 32'h0);
    ptr_txn(8'h40);
    read_txn("R1", 8'h00);

    // R2 write byte, two patterns
    write_txn(8'h22, 8'hA7);
    check(reg_addr == 8'h22, "R2", "pointer after write", {24'd0, reg_addr}, 32'h22);
    write_txn(8'h05, 8'h3C);

    // R3 + R4: set pointer, read twice, pointer kept
    ptr_txn(8'h22);
    read_txn("R4", shadow[8'h22]);
    read_txn("R4", shadow[8'h22]);
    check(reg_addr == 8'h22, "R4", "pointer kept by reads", {24'd0, reg_addr}, 32'h22);
    ptr_txn(8'h80);
    read_txn("R4", shadow[8'h80]);

    // R5 address mismatch
    ptr_txn(8'h22);
    bus_start;
    send_byte({7'h2B, 1'b0}, k);
    check(!k, "R5", "no ACK to foreign address", {31'd0, k}, 32'h0);
    send_byte(8'h05, k);
    check(!k, "R5", "no ACK to ignored byte", {31'd0, k}, 32'h0);
    send_byte(8'h11, k);
    check(!k, "R5", "no ACK to ignored data", {31'd0, k}, 32'h0);
    bus_stop;
    check(reg_addr == 8'h22, "R5", "pointer untouched", {24'd0, reg_addr}, 32'h22);
    read_txn("R5", shadow[8'h22]);

    // R6 repeated start: pointer then read
    bus_start;
    send_byte({DEV, 1'b0}, k);
    send_byte(8'h05, k);
    bus_rstart;
    send_byte({DEV, 1'b1}, k);
    check(k, "R6", "ACK after repeated start", {31'd0, k}, 32'h1);
    recv_byte(d, 1'b1);
    bus_stop;
    check(d == shadow[8'h05], "R6", "read after repeated start", {24'd0, d}, {24'd0, shadow[8'h05]});
    // R6 repeated start after a foreign address
    bus_start;
    send_byte({7'h2B, 1'b0}, k);
    bus_rstart;
    send_byte({DEV, 1'b1}, k);
    check(k, "R6", "ACK after foreign then repeated start", {31'd0, k}, 32'h1);
    recv_byte(d, 1'b1);
    bus_stop;
    check(d == shadow[8'h05], "R6", "read data", {24'd0, d}, {24'd0, shadow[8'h05]});

    // R7 timeout while slave holds SDA low
    write_txn(8'h10, 8'h00);
    bus_start;
    send_byte({DEV, 1'b1}, k);
    recv_bit(b0);
    wait_h(1000);
    check(sda_line == 1'b0, "R7", "SDA held before timeout", {31'd0, sda_line}, 32'h0);
    wait_h(3000);
    check(sda_line == 1'b1, "R7", "SDA released after timeout", {31'd0, sda_line}, 32'h1);
    bus_rstart;
    send_byte({DEV, 1'b1}, k);
    check(k, "R7", "ACK after timeout recovery", {31'd0, k}, 32'h1);
    recv_byte(d, 1'b1);
    bus_stop;
    check(d == 8'h00, "R7", "read after recovery", {24'd0, d}, 32'h0);

    // R8 config register disables timeout
    write_txn(8'h40, 8'h40);
    read_txn("R8", cfg_shadow);
    ptr_txn(8'h10);
    bus_start;
    send_byte({DEV, 1'b1}, k);
    recv_bit(b0);
    d[7] = b0;
    wait_h(8000);
    check(sda_line == 1'b0, "R8", "SDA still held with timeout off", {31'd0, sda_line}, 32'h0);
    for (int i = 6; i >= 0; i--) begin
      recv_bit(b0);
      d[i] = b0;
    end
    send_bit(1'b1);
    bus_stop;
    check(d == 8'h00, "R8", "byte completed after long stall", {24'd0, d}, 32'h0);

    wait_h(10);
    check(wr_q.size() == 0, "R2", "all expected writes seen", wr_q.size(), 32'h0);
    check(drive_viol == 0, "R9", "SDA drive began with SCL high", drive_viol, 32'h0);
    check(sda_oe == 1'b0, "R10", "released after final stop", {31'd0, sda_oe}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule